// File: doc/BRIEF.md
# CPU and Video Memory Timing Generator

This block derives all of the memory and processor timing of a small computer from a single master clock. A 16-step master-cycle counter produces two processor clocks at one sixteenth of the master rate. The first, `cpu_e`, is the main bus clock. The second, `cpu_q`, runs at the same rate and leads `cpu_e` by a quarter period. The block also produces a pixel clock at one quarter of the master rate and a pair of active-low dynamic RAM strobes for the row and column address phases.

Memory time is split by the phase of `cpu_e`. While `cpu_e` is high the processor owns the RAM, and `cpu_grant` is raised. While `cpu_e` is low the video side owns it. The display needs the RAM only on every other bus cycle, so the low-phase strobes appear on alternate periods only.

After reset the pixel clock is held stopped until the counter wraps for the first time. This puts the video timing in a fixed phase relation to the processor timing. The block has no data path, so every pin is a plain control level.

Top module: `mem_timing_gen`

## Requirements
- R1: `cpu_e` is high for master counts 8 to 15 and low for counts 0 to 7. Here the count is the number of rising clock edges since reset was released, modulo 16, so `cpu_e` first rises 8 cycles after release.
- R2: `cpu_q` is high for counts 4 to 11, so it rises 4 master cycles before `cpu_e` does.
- R3: Once running, `pix_clk` has a period of 4 master cycles and is high exactly when the count modulo 4 is 2 or 3.
- R4: `pix_clk` is held low for the first 16 master cycles after reset release and runs from count 0 of the second period onward.
- R5: `cpu_grant` is high exactly when `cpu_e` is high, which gives the RAM to the processor in that half and to video in the other half.
- R6: In every high half of `cpu_e`, let the position inside the half be 0 to 7. `ras_n` is low at positions 1 to 6 and `cas_n` is low at positions 3 to 6, so CAS falls two cycles after RAS.
- R7: The low half of `cpu_e` carries the same RAS/CAS pattern only on odd-numbered periods after reset (the period number is the count of edges since release divided by 16). Period 0 and every other even period have no strobes in that half.
- R8: While reset is asserted, `cpu_e`, `cpu_q`, `pix_clk` and `cpu_grant` are low, and `ras_n` and `cas_n` are high.
- R9: `cas_n` is never low while `ras_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset |
| pix_clk | output | 1 | Pixel clock, master divided by 4, gated after reset |
| cpu_e | output | 1 | Processor bus clock, master divided by 16 |
| cpu_q | output | 1 | Quadrature clock leading `cpu_e` by 4 master cycles |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| cpu_grant | output | 1 | High while the processor owns the RAM |

## Verification
A wrong master count shifts `cpu_e`, `cpu_q` and the strobes together. That error shows at the ports within one 16-cycle period. A faulty alternate-period flag shows up as strobes in the wrong low half within 32 cycles. A faulty pixel gate shows up as a pixel pulse before cycle 16, or as a missing pulse at cycle 18. The bench predicts every output on every cycle of ten periods from the edge count alone, so any departure is caught in the cycle where it first appears.

// File: rtl/mem_timing_pkg.sv
package mem_timing_pkg;
  localparam int PERIOD_LOG2 = 4;
  localparam int PIX_LOG2    = 2;
  localparam int RAS_START   = 1;
  localparam int CAS_DELAY   = 2;
  localparam int STROBE_LAST = 6;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
  } strobe_t;
endpackage

// File: rtl/phase_counter.sv
module phase_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] cnt,
  output logic         wrap,
  output logic         odd_period
);
  localparam logic [W-1:0] LAST = {W{1'b1}};

  assign wrap = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      odd_period <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (wrap) odd_period <= ~odd_period;
    end
  end
endmodule

// File: rtl/pix_gate.sv
module pix_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  input  logic tap,
  output logic pix_clk
);
  logic run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run <= 1'b0;
    else if (wrap) run <= 1'b1;
  end

  assign pix_clk = run & tap;
endmodule

// File: rtl/strobe_gen.sv
module strobe_gen
  import mem_timing_pkg::*;
#(
  parameter int HALF_W = 3
) (
  input  logic [HALF_W-1:0] pos,
  input  logic              active,
  output strobe_t           strb
);
  localparam logic [HALF_W-1:0] RS = RAS_START[HALF_W-1:0];
  localparam logic [HALF_W-1:0] CS = RS + CAS_DELAY[HALF_W-1:0];
  localparam logic [HALF_W-1:0] SL = STROBE_LAST[HALF_W-1:0];

  always_comb begin
    strb.ras_n = ~(active && pos >= RS && pos <= SL);
    strb.cas_n = ~(active && pos >= CS && pos <= SL);
  end
endmodule

// File: rtl/mem_timing_gen.sv
module mem_timing_gen
  import mem_timing_pkg::*;
#(
  parameter int CNT_W = PERIOD_LOG2,
  parameter int PIX_W = PIX_LOG2
) (
  input  logic clk,
  input  logic rst_n,
  output logic pix_clk,
  output logic cpu_e,
  output logic cpu_q,
  output logic ras_n,
  output logic cas_n,
  output logic cpu_grant
);
  localparam int HALF_W = CNT_W - 1;

  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic             odd_period;
  strobe_t          strb;

  phase_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .wrap(wrap), .odd_period(odd_period)
  );

  pix_gate u_pix (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .tap(cnt[PIX_W-1]), .pix_clk(pix_clk)
  );

  assign cpu_e     = cnt[CNT_W-1];
  assign cpu_q     = cnt[CNT_W-1] ^ cnt[CNT_W-2];
  assign cpu_grant = cpu_e;

  strobe_gen #(.HALF_W(HALF_W)) u_strb (
    .pos(cnt[HALF_W-1:0]), .active(cpu_e | odd_period), .strb(strb)
  );

  assign ras_n = strb.ras_n;
  assign cas_n = strb.cas_n;
endmodule

// File: rtl/mem_timing_chk.sv
module mem_timing_chk (
  input logic clk,
  input logic rst_n,
  input logic pix_clk,
  input logic cpu_e,
  input logic cpu_q,
  input logic ras_n,
  input logic cas_n,
  input logic cpu_grant
);
  logic [5:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 6'd63) since_rst <= since_rst + 1'b1;
  end

  assert_e_q_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_e) |-> cpu_q);
  assert_e_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_e) |=> cpu_e);
  assert_pix_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < 6'd16) |-> !pix_clk);
  assert_pix_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_clk) |=> pix_clk ##1 !pix_clk);
  assert_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_grant == cpu_e);
  assert_cas_inside_ras_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);
  assert_ras_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> cas_n);
endmodule

bind mem_timing_gen mem_timing_chk i_chk (
  .clk(clk), .rst_n(rst_n), .pix_clk(pix_clk), .cpu_e(cpu_e), .cpu_q(cpu_q),
  .ras_n(ras_n), .cas_n(cas_n), .cpu_grant(cpu_grant)
);

// File: tb/test_mem_timing_gen.sv
module test_mem_timing_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_clk, cpu_e, cpu_q, ras_n, cas_n, cpu_grant;
  int   vectors = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  mem_timing_gen i_mem_timing_gen (
    .clk(clk), .rst_n(rst_n), .pix_clk(pix_clk), .cpu_e(cpu_e), .cpu_q(cpu_q),
    .ras_n(ras_n), .cas_n(cas_n), .cpu_grant(cpu_grant)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  initial begin
    #20000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 e", cpu_e, 1'b0);
    chk("R8 q", cpu_q, 1'b0);
    chk("R8 pix", pix_clk, 1'b0);
    chk("R8 grant", cpu_grant, 1'b0);
    chk("R8 ras", ras_n, 1'b1);
    chk("R8 cas", cas_n, 1'b1);
    rst_n = 1'b1;
    for (int k = 1; k <= 160; k++) begin
      int c, l;
      bit e, q, act;
      @(negedge clk);
      c   = k % 16;
      l   = c % 8;
      e   = (c >= 8);
      q   = (c >= 4) && (c < 12);
      act = e || ((k / 16) % 2 == 1);
      chk("R1 cpu_e", cpu_e, e);
      chk("R2 cpu_q", cpu_q, q);
      chk("R3/R4 pix_clk", pix_clk, (k >= 16) && ((c % 4) >= 2));
      chk("R5 cpu_grant", cpu_grant, e);
      chk("R6/R7 ras_n", ras_n, !(act && l >= 1 && l <= 6));
      chk("R6/R7 cas_n", cas_n, !(act && l >= 3 && l <= 6));
      chk("R9 order", !cas_n && ras_n, 1'b0);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule